// File: doc/BRIEF.md
# DDR Serial Output Shifter with Pin Crossbar

This block turns a stream of 32-bit words into double-data-rate activity on eight output pins. Words enter through a write-only FIFO. A 32-bit output register is loaded from that FIFO and rotated right by a programmable amount on every enabled system clock. After a programmable number of displayed cycles, the register takes the next word.

Each pin has its own selector. The selector picks one register bit for the first half of the system clock cycle and a second bit for the second half. The two half-cycle values are presented as separate outputs for a DDR pad cell outside the block. A pin can drive a divided clock instead of data. The divided clock has a programmable period and start phase. Either source can be inverted per pin.

The FIFO reports its word count, a sticky overflow flag and a data request for a DMA engine. Typical use is serializing pre-encoded symbols, such as 10-bit line codes, in which several pins carry data lanes and a pin pair carries the matching clock.

Top module: `ddr_pin_shifter`

## Requirements
- R1: While enabled, on every cycle that does not load a new word, the output register rotates right by `shift_amt` bits (0 to 31). A value of 0 leaves it unchanged.
- R2: After a load, the loaded word stays in the register for N cycles (N-1 rotations) before the next load, where N is `shift_cnt`. A `shift_cnt` of 0 means N = 32.
- R3: Each pin has a 12-bit config at `pin_cfg[12*i +: 12]` with these fields:
  - bits [4:0] select the register bit driven on `pin_p[i]` (first half-cycle).
  - bits [9:5] select the register bit driven on `pin_n[i]` (second half-cycle).
- R4: Config bit 10 inverts both half-cycle outputs of the pin. Inversion applies to data and to the generated clock alike.
- R5: When config bit 11 is set, the pin outputs the generated clock.
  - The clock period is D system cycles, with D = `clk_div`, and 0 means 16.
  - A phase counter counts half-cycles modulo 2D, advances by 2 per enabled cycle, and starts at `clk_phase` mod 2D.
  - The clock is high while the half-cycle position is below D.
- R6: The FIFO holds 8 words. `fifo_level` reports the current count (0 to 8).
- R7: A write while the FIFO holds 8 words is dropped and sets `ovf_flag`. The flag stays set until `ovf_clear` is asserted. A new overflow in the same cycle as a clear leaves the flag set.
- R8: `dreq` is high exactly when `fifo_level` is below 8.
- R9: If the FIFO is empty when a load is due, the register keeps rotating by `shift_amt`. It loads on the first cycle a word is present, and that word then gets a full N cycles.
- R10: With `enable` low, all pins drive 0 before inversion and the load counter clears. The clock phase is re-armed to `clk_phase` mod 2D. The FIFO still accepts writes.
- R11: With `shift_amt` 2, `shift_cnt` 5 and `clk_div` 5, a pin selecting bits 0 and 1 emits the ten low bits of each word in order over five cycles. In that same span the clock pin is high for exactly five of its ten half-cycles.
- R12: After synchronous reset the FIFO is empty, `ovf_flag` is 0, the register is 0 and the phase counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the shifter and clock generator |
| shift_amt | input | 5 | Right-rotate amount per cycle |
| shift_cnt | input | 5 | Cycles per word (0 = 32) |
| clk_div | input | 4 | Generated clock period in cycles (0 = 16) |
| clk_phase | input | 4 | Start phase of generated clock, in half-cycles |
| pin_cfg | input | 96 | Eight 12-bit pin configs |
| wr_valid | input | 1 | Push a word into the FIFO |
| wr_data | input | 32 | Word to push |
| ovf_clear | input | 1 | Clear the overflow flag |
| fifo_level | output | 4 | Words held in the FIFO |
| ovf_flag | output | 1 | Sticky write-overflow flag |
| dreq | output | 1 | FIFO can accept a word |
| pin_p | output | 8 | First half-cycle pin values |
| pin_n | output | 8 | Second half-cycle pin values |

## Verification
The bench targets four kinds of corner case.

- **Reload count of 0.** A design that treats it literally would reload every cycle instead of every 32. Likewise, a clock divider of 0 handled literally would stall or run as a one-cycle clock instead of a 16-cycle one.
- **Starvation.** A design that stopped rotating, or that counted a starved cycle against the next word, shifts every later pin bit out of step.
- **Overflow.** A push into a full FIFO that is not dropped would overwrite queued data. A clear that beats a simultaneous overflow would lose the event.
- **Phase wrap and the fixed 2/5/5 configuration.** An off-by-one in the half-cycle phase wrap, or in the rotate-then-reload order, breaks the ten-bits-per-clock-period alignment.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int DW     = 32;
    localparam int SELW   = $clog2(DW);
    localparam int PIN_N  = 8;
    localparam int FIFO_D = 8;

    typedef struct packed {
        logic            clk_sel;
        logic            inv;
        logic [SELW-1:0] sel_n;
        logic [SELW-1:0] sel_p;
    } pin_cfg_t;

    localparam int CFGW = $bits(pin_cfg_t);

    function automatic logic [DW-1:0] ror(input logic [DW-1:0] v, input logic [SELW-1:0] k);
        logic [2*DW-1:0] d;
        d = {v, v} >> k;
        return d[DW-1:0];
    endfunction

    function automatic logic [SELW:0] span_of(input logic [SELW-1:0] n);
        return (n == '0) ? (SELW+1)'(DW) : {1'b0, n};
    endfunction

    function automatic logic [5:0] half_period(input logic [3:0] div);
        return (div == 4'd0) ? 6'd32 : {1'b0, div, 1'b0};
    endfunction

    function automatic logic [5:0] phase_wrap(input logic [3:0] ph, input logic [5:0] p2);
        logic [5:0] r;
        r = {2'b00, ph};
        for (int i = 0; i < 8; i++) begin
            if (r >= p2) r = r - p2;
        end
        return r;
    endfunction

endpackage

// File: rtl/dps_fifo.sv
module dps_fifo
    import dps_pkg::*;
#(
    parameter int DEPTH = FIFO_D,
    parameter int W     = DW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    input  logic                       clr,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       ovf,
    output logic                       ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, accept;

    assign full   = (level == LW'(DEPTH));
    assign accept = push && !full;
    assign empty  = (level == '0);
    assign ready  = !full;
    assign head   = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            if (accept) wp <= bump(wp);
            if (pop)    rp <= bump(rp);
            level <= level + LW'(accept) - LW'(pop);
            if (push && full) ovf <= 1'b1;
            else if (clr)     ovf <= 1'b0;
        end
    end

    p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));
    p_ovf_set_r7: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> ovf);
    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);
    p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/dps_shifter.sv
module dps_shifter
    import dps_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [SELW-1:0] amt,
    input  logic [SELW-1:0] cnt_cfg,
    input  logic            avail,
    input  logic [DW-1:0]   word,
    output logic            take,
    output logic [DW-1:0]   sr
);
    logic [SELW:0] left;

    assign take = en && (left <= (SELW+1)'(1)) && avail;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            left <= '0;
        end else if (!en) begin
            left <= '0;
        end else if (take) begin
            sr   <= word;
            left <= span_of(cnt_cfg);
        end else begin
            sr   <= ror(sr, amt);
            left <= (left > (SELW+1)'(1)) ? left - 1'b1 : '0;
        end
    end

    p_rotate_r1: assert property (@(posedge clk) disable iff (rst)
        (en && !take) |=> sr == ror($past(sr), $past(amt)));
    p_span_bound_r2: assert property (@(posedge clk) disable iff (rst)
        left <= (SELW+1)'(DW));

endmodule

// File: rtl/dps_clkgen.sv
module dps_clkgen
    import dps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] div,
    input  logic [3:0] phase,
    output logic       ck_p,
    output logic       ck_n
);
    logic [5:0] ph, p2, hi_len, ph_adv, ph_half;

    assign p2      = half_period(div);
    assign hi_len  = p2 >> 1;
    assign ph_adv  = (ph + 6'd2 >= p2) ? ph + 6'd2 - p2 : ph + 6'd2;
    assign ph_half = (ph + 6'd1 >= p2) ? ph + 6'd1 - p2 : ph + 6'd1;
    assign ck_p    = ph < hi_len;
    assign ck_n    = ph_half < hi_len;

    always_ff @(posedge clk) begin
        if (rst)       ph <= '0;
        else if (!en)  ph <= phase_wrap(phase, p2);
        else           ph <= ph_adv;
    end

    p_phase_rearm_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> ph < 6'd16);

endmodule

// File: rtl/dps_pin_lane.sv
module dps_pin_lane
    import dps_pkg::*;
(
    input  logic          en,
    input  pin_cfg_t      cfg,
    input  logic [DW-1:0] sr,
    input  logic          ck_p,
    input  logic          ck_n,
    output logic          o_p,
    output logic          o_n
);
    logic raw_p, raw_n;

    always_comb begin
        raw_p = 1'b0;
        raw_n = 1'b0;
        if (en) begin
            raw_p = cfg.clk_sel ? ck_p : sr[cfg.sel_p];
            raw_n = cfg.clk_sel ? ck_n : sr[cfg.sel_n];
        end
    end

    assign o_p = raw_p ^ cfg.inv;
    assign o_n = raw_n ^ cfg.inv;

endmodule

// File: rtl/ddr_pin_shifter.sv
module ddr_pin_shifter
    import dps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [SELW-1:0]       shift_amt,
    input  logic [SELW-1:0]       shift_cnt,
    input  logic [3:0]            clk_div,
    input  logic [3:0]            clk_phase,
    input  logic [PIN_N*CFGW-1:0] pin_cfg,
    input  logic                  wr_valid,
    input  logic [DW-1:0]         wr_data,
    input  logic                  ovf_clear,
    output logic [3:0]            fifo_level,
    output logic                  ovf_flag,
    output logic                  dreq,
    output logic [PIN_N-1:0]      pin_p,
    output logic [PIN_N-1:0]      pin_n
);
    logic [DW-1:0]    head, sr;
    logic             empty, take, ck_p, ck_n;
    logic [PIN_N-1:0] inv_vec;

    dps_fifo #(.DEPTH(FIFO_D), .W(DW)) u_fifo (
        .clk(clk), .rst(rst), .push(wr_valid), .push_data(wr_data),
        .pop(take), .clr(ovf_clear), .head(head), .level(fifo_level),
        .empty(empty), .ovf(ovf_flag), .ready(dreq)
    );

    dps_shifter u_shift (
        .clk(clk), .rst(rst), .en(enable), .amt(shift_amt), .cnt_cfg(shift_cnt),
        .avail(!empty), .word(head), .take(take), .sr(sr)
    );

    dps_clkgen u_clk (
        .clk(clk), .rst(rst), .en(enable), .div(clk_div), .phase(clk_phase),
        .ck_p(ck_p), .ck_n(ck_n)
    );

    for (genvar i = 0; i < PIN_N; i++) begin : g_lane
        pin_cfg_t c;
        assign c          = pin_cfg[i*CFGW +: CFGW];
        assign inv_vec[i] = c.inv;
        dps_pin_lane u_lane (
            .en(enable), .cfg(c), .sr(sr), .ck_p(ck_p), .ck_n(ck_n),
            .o_p(pin_p[i]), .o_n(pin_n[i])
        );
    end

    p_idle_pins_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |-> ((pin_p ^ inv_vec) == '0 && (pin_n ^ inv_vec) == '0));
    p_dreq_level_r8: assert property (@(posedge clk) disable iff (rst)
        !dreq |-> fifo_level == 4'd8);

endmodule

// File: tb/ddr_pin_shifter_bench.sv
module ddr_pin_shifter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [4:0]  shift_amt = '0, shift_cnt = '0;
    logic [3:0]  clk_div = '0, clk_phase = '0;
    logic [95:0] pin_cfg = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ovf_clear = 1'b0;
    logic [3:0]  fifo_level;
    logic        ovf_flag, dreq;
    logic [7:0]  pin_p, pin_n;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    ddr_pin_shifter u_ddr_pin_shifter (
        .clk(clk), .rst(rst), .enable(enable), .shift_amt(shift_amt),
        .shift_cnt(shift_cnt), .clk_div(clk_div), .clk_phase(clk_phase),
        .pin_cfg(pin_cfg), .wr_valid(wr_valid), .wr_data(wr_data),
        .ovf_clear(ovf_clear), .fifo_level(fifo_level), .ovf_flag(ovf_flag),
        .dreq(dreq), .pin_p(pin_p), .pin_n(pin_n)
    );

    // behavioural reference state
    logic [31:0] msr = '0;
    int          mcnt = 0, mph = 0;
    logic [31:0] q[$];
    bit          movf = 0;

    function automatic int per2();
        return (clk_div == 0) ? 32 : 2 * int'(clk_div);
    endfunction

    function automatic logic [15:0] model_pins();
        logic [7:0] p, n;
        int d;
        d = per2() / 2;
        for (int i = 0; i < 8; i++) begin
            logic [11:0] c;
            logic a, b;
            c = pin_cfg[i*12 +: 12];
            a = 0; b = 0;
            if (enable) begin
                a = c[11] ? (mph < d) : msr[c[4:0]];
                b = c[11] ? (((mph + 1) % per2()) < d) : msr[c[9:5]];
            end
            p[i] = a ^ c[10];
            n[i] = b ^ c[10];
        end
        return {n, p};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit pop, full;
        logic [31:0] w;
        logic [63:0] d;
        pop  = enable && mcnt <= 1 && q.size() > 0;
        full = (q.size() == 8);
        w = '0;
        if (pop) w = q.pop_front();
        if (wr_valid && !full) q.push_back(wr_data);
        if (wr_valid && full) movf = 1;
        else if (ovf_clear)   movf = 0;
        if (enable) begin
            if (pop) begin
                msr  = w;
                mcnt = (shift_cnt == 0) ? 32 : int'(shift_cnt);
            end else begin
                d    = {msr, msr} >> shift_amt;
                msr  = d[31:0];
                mcnt = (mcnt > 1) ? mcnt - 1 : 0;
            end
            mph = (mph + 2) % per2();
        end else begin
            mcnt = 0;
            mph  = int'(clk_phase) % per2();
        end
    endtask

    task automatic step();
        #2;
        check("R6 level", 64'(fifo_level), 64'(q.size()));
        check("R7 overflow flag", 64'(ovf_flag), 64'(movf));
        check("R8 dreq", 64'(dreq), 64'(q.size() < 8));
        check("R1/R2/R3/R4/R5/R9/R10 pins", 64'({pin_n, pin_p}), 64'(model_pins()));
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic rand_traffic(input int cycles, input int push_mod);
        for (int k = 0; k < cycles; k++) begin
            wr_valid  = ($urandom % push_mod) == 0;
            wr_data   = $urandom;
            ovf_clear = ($urandom % 23) == 0;
            step();
        end
        wr_valid  = 0;
        ovf_clear = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] w1;
        logic [9:0]  got;
        int          hi;

        @(negedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        // R12 reset state
        check("R12 level after reset", 64'(fifo_level), 0);
        check("R12 ovf after reset", 64'(ovf_flag), 0);
        check("R12 pins after reset", 64'({pin_n, pin_p}), 0);
        @(negedge clk);

        // R10: FIFO fills while disabled
        w1 = 32'h2C5A_93B6;
        wr_valid = 1;
        wr_data = w1;
        step();
        wr_data = 32'h0F0F_3CC3;
        step();
        wr_data = 32'hA5A5_1234;
        step();
        wr_valid = 0;
        step();
        check("R10 writes accepted while disabled", 64'(fifo_level), 3);

        // R11 fixed configuration
        shift_amt = 2;
        shift_cnt = 5;
        clk_div = 5;
        clk_phase = 0;
        pin_cfg[0*12 +: 12] = {1'b0, 1'b0, 5'd1, 5'd0};
        pin_cfg[1*12 +: 12] = {1'b0, 1'b1, 5'd1, 5'd0};
        pin_cfg[2*12 +: 12] = {1'b1, 1'b0, 5'd0, 5'd0};
        pin_cfg[3*12 +: 12] = {1'b1, 1'b1, 5'd0, 5'd0};
        pin_cfg[4*12 +: 12] = {1'b0, 1'b0, 5'd11, 5'd10};
        pin_cfg[5*12 +: 12] = {1'b0, 1'b1, 5'd21, 5'd20};
        pin_cfg[6*12 +: 12] = {1'b0, 1'b0, 5'd31, 5'd30};
        pin_cfg[7*12 +: 12] = {1'b1, 1'b0, 5'd0, 5'd0};
        step();  // re-arm phase with the new divider
        enable = 1;
        step();  // first enabled cycle loads word 1
        got = '0;
        hi = 0;
        for (int k = 0; k < 5; k++) begin
            #2;
            got[2*k]   = pin_p[0];
            got[2*k+1] = pin_n[0];
            hi += int'(pin_p[2]) + int'(pin_n[2]);
            step();
        end
        check("R11 ten bits per word", 64'(got), 64'(w1[9:0]));
        check("R11 clock high halves per word", 64'(hi), 5);
        rand_traffic(80, 6);  // sparse pushes exercise starvation (R9)

        // R2/R5 zero encodings: 32 cycles per word, 16-cycle clock
        enable = 0;
        step();
        shift_amt = 5'd3;
        shift_cnt = 5'd0;
        clk_div = 4'd0;
        clk_phase = 4'd7;
        step();
        enable = 1;
        rand_traffic(200, 4);

        // R7/R6/R8 overflow
        enable = 0;
        wr_valid = 1;
        for (int k = 0; k < 12; k++) begin
            wr_data = $urandom;
            step();
        end
        wr_valid = 0;
        #2;
        check("R6 level saturates at 8", 64'(fifo_level), 8);
        check("R7 overflow set", 64'(ovf_flag), 1);
        check("R8 dreq low when full", 64'(dreq), 0);
        @(negedge clk);
        // clear and overflow in the same cycle: flag stays set
        wr_valid = 1;
        ovf_clear = 1;
        step();
        wr_valid = 0;
        ovf_clear = 0;
        #2;
        check("R7 overflow beats clear", 64'(ovf_flag), 1);
        @(negedge clk);
        ovf_clear = 1;
        step();
        ovf_clear = 0;
        #2;
        check("R7 overflow cleared", 64'(ovf_flag), 0);
        @(negedge clk);

        // random configurations, changed only while disabled
        for (int r = 0; r < 8; r++) begin
            enable = 0;
            step();
            shift_amt = 5'($urandom);
            shift_cnt = 5'($urandom % 6);
            clk_div = 4'($urandom);
            clk_phase = 4'($urandom);
            pin_cfg = {$urandom, $urandom, $urandom};
            step();
            enable = 1;
            rand_traffic(150, 2 + r % 4);
        end
        finish_run();
    end

endmodule